// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block steps a processor core into and out of an interrupt handler. Each cycle it looks at a pending interrupt request, with its priority level and its 14-bit event code, and compares it against the core's current status word. When it takes the request, it copies the program counter, the status word and the stack-pointer register (general register 15) into three shadow registers. It then issues a new status word with the privilege, bank-select and exception-block bits raised, latches the event code, and loads the fetch address with the vector base plus a fixed handler offset.

A return strobe undoes the entry. The block issues a program-counter load from the shadow PC and a status load from the shadow status. The shadow copy of register 15 is never written back: the block has no path to the register file for it, so `sgr` simply holds its value. An optional mode replaces the status word's interrupt-mask field with the level of the request that was just taken. A request flagged as reset-type also clears the FPU-disable bit.

The core consumes `pc_load`/`next_pc` and `sr_load`/`next_sr` as one-cycle load commands. The interrupt source watches `accept_pulse` to drop its request.

Top module: `irq_entry_seq`

## Requirements
- R1: On an entry, `spc`, `ssr` and `sgr` take the values `cur_pc`, `cur_sr` and `cur_r15` sampled in the cycle the request was taken, all on the same clock edge.
- R2: On an entry, `next_sr` equals `cur_sr` with bit 30 (privileged mode), bit 29 (bank select) and bit 28 (exception block) set to 1, apart from the changes listed in R5 and R7.
- R3: On an entry, `intevt[13:0]` takes `irq_code` and `intevt[31:14]` reads 0. `intevt` keeps its value until the next entry.
- R4: On an entry, `next_pc` equals `vbr + 0x600`.
- R5: On an entry with `mask_upd_en` = 1, `next_sr[7:4]` equals `irq_level`. With `mask_upd_en` = 0, `next_sr[7:4]` equals `cur_sr[7:4]`.
- R6: When `rte_strobe` is 1, the next cycle has `pc_load` = 1 with `next_pc` = `spc`, and `sr_load` = 1 with `next_sr` = `ssr`. `sgr` is left unchanged.
- R7: A request with `irq_reset_type` = 1 is taken whatever the block bit and mask are, and its `next_sr[15]` (FPU disable) is 0. An ordinary entry passes bit 15 through unchanged.
- R8: An ordinary request is taken only when `cur_sr[28]` is 0 and `irq_level` is strictly greater than `cur_sr[7:4]`. Otherwise it produces no entry and no load.
- R9: When `rte_strobe` and a request that could be taken arrive in the same cycle, only the return happens. The request is evaluated again in the next cycle.
- R10: Each entry raises `accept_pulse`, `pc_load` and `sr_load` for exactly one cycle, in the cycle after the request was sampled.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | XLEN | Current program counter |
| cur_sr | input | 32 | Current status word |
| cur_r15 | input | XLEN | Current general register 15 |
| vbr | input | XLEN | Vector base |
| irq_req | input | 1 | Interrupt request pending |
| irq_level | input | 4 | Priority level of the request |
| irq_code | input | CODE_W | Event code of the request |
| irq_reset_type | input | 1 | Request is a reset-type entry |
| rte_strobe | input | 1 | Return-from-exception strobe |
| mask_upd_en | input | 1 | Rewrite the mask field to the taken level |
| accept_pulse | output | 1 | One-cycle entry indication |
| pc_load | output | 1 | Load `next_pc` into the PC |
| next_pc | output | XLEN | PC value to load |
| sr_load | output | 1 | Load `next_sr` into the status word |
| next_sr | output | 32 | Status value to load |
| spc | output | XLEN | Saved PC |
| ssr | output | 32 | Saved status word |
| sgr | output | XLEN | Saved general register 15 |
| intevt | output | XLEN | Interrupt event register |

## Verification
Every result is registered once, so the outputs that follow a request or return strobe sampled at one edge are present only during the following cycle. The load pulses fall again one cycle later. The bench drives inputs on falling edges and compares on the next falling edge, which lands exactly in that result cycle. It compares once more one falling edge later to confirm that the pulses have dropped and that the event register and shadow registers hold their values. The sweep covers every pairing of level and mask, with the block bit and the mask-update mode each on and off. For the return-priority case, the request is held through the return cycle and the entry is expected in the cycle after it.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  // status word layout
  localparam int SR_W        = 32;
  localparam int SR_MD       = 30;
  localparam int SR_RB       = 29;
  localparam int SR_BL       = 28;
  localparam int SR_FD       = 15;
  localparam int IMASK_LO    = 4;
  localparam int IMASK_W     = 4;

  // decision produced each cycle
  typedef struct packed {
    logic enter;
    logic leave;
  } seq_cmd_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_entry_pkg::*;
(
  input  logic               req,
  input  logic [IMASK_W-1:0] level,
  input  logic [SR_W-1:0]    sr,
  input  logic               reset_type,
  input  logic               rte,
  output seq_cmd_t           cmd
);
  logic [IMASK_W-1:0] cur_mask;
  logic               unmasked;
  logic               eligible;

  always_comb begin
    cur_mask  = sr[IMASK_LO +: IMASK_W];
    unmasked  = !sr[SR_BL] && (level > cur_mask);
    eligible  = req && (reset_type || unmasked);
    // return wins; a held request is looked at again next cycle
    cmd.leave = rte;
    cmd.enter = eligible && !rte;
  end
endmodule

// File: rtl/irq_sr_compose.sv
module irq_sr_compose
  import irq_entry_pkg::*;
#(
  parameter bit HAS_MASK_UPD = 1'b1
)(
  input  logic [SR_W-1:0]    sr_in,
  input  logic [IMASK_W-1:0] level,
  input  logic               upd_en,
  input  logic               reset_type,
  output logic [SR_W-1:0]    sr_out
);
  logic [SR_W-1:0]    flagged;
  logic [IMASK_W-1:0] new_mask;

  always_comb begin
    flagged         = sr_in;
    flagged[SR_MD]  = 1'b1;
    flagged[SR_RB]  = 1'b1;
    flagged[SR_BL]  = 1'b1;
    if (reset_type) flagged[SR_FD] = 1'b0;
  end

  generate
    if (HAS_MASK_UPD) begin : g_mask_upd
      assign new_mask = upd_en ? level : sr_in[IMASK_LO +: IMASK_W];
    end else begin : g_mask_keep
      logic unused_upd;
      assign unused_upd = upd_en ^ (^level);
      assign new_mask   = sr_in[IMASK_LO +: IMASK_W];
    end
  endgenerate

  always_comb begin
    sr_out                       = flagged;
    sr_out[IMASK_LO +: IMASK_W]  = new_mask;
  end
endmodule

// File: rtl/irq_shadow_bank.sv
module irq_shadow_bank
  import irq_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 14
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [SR_W-1:0]   sr_in,
  input  logic [XLEN-1:0]   gr_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [XLEN-1:0]   spc,
  output logic [SR_W-1:0]   ssr,
  output logic [XLEN-1:0]   sgr,
  output logic [XLEN-1:0]   intevt
);
  localparam int PAD_W = XLEN - CODE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      spc    <= '0;
      ssr    <= '0;
      sgr    <= '0;
      intevt <= '0;
    end else if (capture) begin
      spc    <= pc_in;
      ssr    <= sr_in;
      sgr    <= gr_in;
      intevt <= {{PAD_W{1'b0}}, code_in};
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          CODE_W       = 14,
  parameter int unsigned VEC_OFFSET   = 32'h600,
  parameter bit          HAS_MASK_UPD = 1'b1
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [SR_W-1:0]    cur_sr,
  input  logic [XLEN-1:0]    cur_r15,
  input  logic [XLEN-1:0]    vbr,
  input  logic               irq_req,
  input  logic [IMASK_W-1:0] irq_level,
  input  logic [CODE_W-1:0]  irq_code,
  input  logic               irq_reset_type,
  input  logic               rte_strobe,
  input  logic               mask_upd_en,
  output logic               accept_pulse,
  output logic               pc_load,
  output logic [XLEN-1:0]    next_pc,
  output logic               sr_load,
  output logic [SR_W-1:0]    next_sr,
  output logic [XLEN-1:0]    spc,
  output logic [SR_W-1:0]    ssr,
  output logic [XLEN-1:0]    sgr,
  output logic [XLEN-1:0]    intevt
);
  localparam logic [XLEN-1:0] OFFSET = XLEN'(VEC_OFFSET);

  seq_cmd_t        cmd;
  logic [SR_W-1:0] entry_sr;

  irq_gate u_gate (
    .req        (irq_req),
    .level      (irq_level),
    .sr         (cur_sr),
    .reset_type (irq_reset_type),
    .rte        (rte_strobe),
    .cmd        (cmd)
  );

  irq_sr_compose #(.HAS_MASK_UPD(HAS_MASK_UPD)) u_compose (
    .sr_in      (cur_sr),
    .level      (irq_level),
    .upd_en     (mask_upd_en),
    .reset_type (irq_reset_type),
    .sr_out     (entry_sr)
  );

  irq_shadow_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .capture (cmd.enter),
    .pc_in   (cur_pc),
    .sr_in   (cur_sr),
    .gr_in   (cur_r15),
    .code_in (irq_code),
    .spc     (spc),
    .ssr     (ssr),
    .sgr     (sgr),
    .intevt  (intevt)
  );

  // load commands toward the core, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      accept_pulse <= 1'b0;
      pc_load      <= 1'b0;
      sr_load      <= 1'b0;
      next_pc      <= '0;
      next_sr      <= '0;
    end else begin
      accept_pulse <= 1'b0;
      pc_load      <= 1'b0;
      sr_load      <= 1'b0;
      if (cmd.leave) begin
        pc_load <= 1'b1;
        sr_load <= 1'b1;
        next_pc <= spc;
        next_sr <= ssr;
      end else if (cmd.enter) begin
        accept_pulse <= 1'b1;
        pc_load      <= 1'b1;
        sr_load      <= 1'b1;
        next_pc      <= vbr + OFFSET;
        next_sr      <= entry_sr;
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
  import irq_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          CODE_W     = 14,
  parameter int unsigned VEC_OFFSET = 32'h600
)(
  input logic               clk,
  input logic               rst,
  input logic [XLEN-1:0]    cur_pc,
  input logic [SR_W-1:0]    cur_sr,
  input logic [XLEN-1:0]    cur_r15,
  input logic [XLEN-1:0]    vbr,
  input logic               irq_req,
  input logic [IMASK_W-1:0] irq_level,
  input logic [CODE_W-1:0]  irq_code,
  input logic               irq_reset_type,
  input logic               rte_strobe,
  input logic               mask_upd_en,
  input logic               accept_pulse,
  input logic               pc_load,
  input logic [XLEN-1:0]    next_pc,
  input logic               sr_load,
  input logic [SR_W-1:0]    next_sr,
  input logic [XLEN-1:0]    spc,
  input logic [SR_W-1:0]    ssr,
  input logic [XLEN-1:0]    sgr,
  input logic [XLEN-1:0]    intevt
);
  localparam logic [XLEN-1:0] OFFSET = XLEN'(VEC_OFFSET);

  AST_SAVE_TRIPLE: assert property (@(posedge clk) disable iff (rst)
    accept_pulse |-> (spc == $past(cur_pc) && ssr == $past(cur_sr) && sgr == $past(cur_r15))); // R1

  AST_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    accept_pulse |-> (next_sr[SR_MD] && next_sr[SR_RB] && next_sr[SR_BL])); // R2

  AST_EVENT_CODE: assert property (@(posedge clk) disable iff (rst)
    accept_pulse |-> (intevt[CODE_W-1:0] == $past(irq_code) && intevt[XLEN-1:CODE_W] == '0)); // R3

  AST_VECTOR_PC: assert property (@(posedge clk) disable iff (rst)
    accept_pulse |-> (next_pc == $past(vbr) + OFFSET)); // R4

  AST_MASK_UPD: assert property (@(posedge clk) disable iff (rst)
    (accept_pulse && $past(mask_upd_en)) |-> (next_sr[IMASK_LO +: IMASK_W] == $past(irq_level))); // R5

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    (accept_pulse && !$past(mask_upd_en)) |-> (next_sr[IMASK_LO +: IMASK_W] == $past(cur_sr[IMASK_LO +: IMASK_W]))); // R5

  AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(rte_strobe) && !$past(rst)) |-> (pc_load && sr_load && next_pc == $past(spc) && next_sr == $past(ssr))); // R6

  AST_SGR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept_pulse |-> $stable(sgr)); // R6

  AST_RESET_FD: assert property (@(posedge clk) disable iff (rst)
    (accept_pulse && $past(irq_reset_type)) |-> !next_sr[SR_FD]); // R7

  AST_ACCEPT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    accept_pulse |-> $past(irq_req && (irq_reset_type ||
      (!cur_sr[SR_BL] && irq_level > cur_sr[IMASK_LO +: IMASK_W])))); // R8

  AST_RETURN_FIRST: assert property (@(posedge clk) disable iff (rst)
    $past(rte_strobe) |-> !accept_pulse); // R9

  AST_PULSE_LOADS: assert property (@(posedge clk) disable iff (rst)
    accept_pulse |-> (pc_load && sr_load)); // R10
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .VEC_OFFSET(VEC_OFFSET)
) u_chk (
  .clk(clk), .rst(rst), .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_r15(cur_r15),
  .vbr(vbr), .irq_req(irq_req), .irq_level(irq_level), .irq_code(irq_code),
  .irq_reset_type(irq_reset_type), .rte_strobe(rte_strobe),
  .mask_upd_en(mask_upd_en), .accept_pulse(accept_pulse), .pc_load(pc_load),
  .next_pc(next_pc), .sr_load(sr_load), .next_sr(next_sr), .spc(spc),
  .ssr(ssr), .sgr(sgr), .intevt(intevt)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cur_pc = '0, cur_sr = '0, cur_r15 = '0, vbr = '0;
  logic        irq_req = 1'b0;
  logic [3:0]  irq_level = '0;
  logic [13:0] irq_code = '0;
  logic        irq_reset_type = 1'b0, rte_strobe = 1'b0, mask_upd_en = 1'b0;
  logic        accept_pulse, pc_load, sr_load;
  logic [31:0] next_pc, next_sr, spc, ssr, sgr, intevt;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_r15(cur_r15),
    .vbr(vbr), .irq_req(irq_req), .irq_level(irq_level), .irq_code(irq_code),
    .irq_reset_type(irq_reset_type), .rte_strobe(rte_strobe),
    .mask_upd_en(mask_upd_en), .accept_pulse(accept_pulse), .pc_load(pc_load),
    .next_pc(next_pc), .sr_load(sr_load), .next_sr(next_sr), .spc(spc),
    .ssr(ssr), .sgr(sgr), .intevt(intevt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected entry status word, from the requirements
  function automatic logic [31:0] exp_sr(input logic [31:0] sr, input logic [3:0] lvl,
                                         input logic upd, input logic rtype);
    logic [31:0] e;
    e = sr | 32'h7000_0000;             // bits 30,29,28
    if (upd) e[7:4] = lvl;
    if (rtype) e[15] = 1'b0;
    return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] last_evt, sv_pc, sv_sr, sv_gr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 accept", {31'b0, accept_pulse}, 0);
    chk("R11 pc_load", {31'b0, pc_load}, 0);
    chk("R11 sr_load", {31'b0, sr_load}, 0);
    chk("R11 next_pc", next_pc, 0);
    chk("R11 next_sr", next_sr, 0);
    chk("R11 spc", spc, 0);
    chk("R11 ssr", ssr, 0);
    chk("R11 sgr", sgr, 0);
    chk("R11 intevt", intevt, 0);
    last_evt = 0;

    // sweep: block bit x mask-update x mask x level
    for (int bl = 0; bl < 2; bl++)
      for (int upd = 0; upd < 2; upd++)
        for (int m = 0; m < 16; m++)
          for (int l = 0; l < 16; l++) begin
            logic acc;
            logic [31:0] sr_v;
            sr_v           = 32'h0000_8003 | (32'(bl) << 28) | (32'(m) << 4);
            cur_sr         = sr_v;
            cur_pc         = 32'h0C00_0000 + 32'(l * 64 + m * 4 + bl);
            cur_r15        = 32'hA500_0000 + 32'(m * 256 + l);
            vbr            = 32'h8000_0000 + 32'(l) * 32'h1000;
            irq_level      = 4'(l);
            irq_code       = 14'(l * 37 + m * 5 + bl + 100 * upd);
            mask_upd_en    = upd[0];
            irq_req        = 1'b1;
            @(negedge clk);
            irq_req = 1'b0;
            acc = (bl == 0) && (l > m);
            chk("R8 accept", {31'b0, accept_pulse}, {31'b0, acc});
            chk("R10 pc_load", {31'b0, pc_load}, {31'b0, acc});
            if (acc) begin
              chk("R4 next_pc", next_pc, vbr + 32'h600);
              chk("R2 next_sr", next_sr, exp_sr(sr_v, 4'(l), upd[0], 1'b0));
              chk("R5 mask", {28'b0, next_sr[7:4]}, upd ? 32'(l) : 32'(m));
              chk("R7 fd kept", {31'b0, next_sr[15]}, 1);
              chk("R1 spc", spc, cur_pc);
              chk("R1 ssr", ssr, sr_v);
              chk("R1 sgr", sgr, cur_r15);
              chk("R3 intevt", intevt, {18'b0, irq_code});
              last_evt = {18'b0, irq_code};
            end else begin
              chk("R3 intevt hold", intevt, last_evt);
            end
            @(negedge clk);
            chk("R10 one cycle", {30'b0, accept_pulse, pc_load}, 0);
            chk("R3 intevt hold", intevt, last_evt);
          end

    // R6 / R9: return together with an acceptable request
    sv_pc = spc; sv_sr = ssr; sv_gr = sgr;
    cur_sr = 32'h0000_0000; irq_level = 4'd9; mask_upd_en = 1'b0;
    cur_r15 = 32'h1234_5678; cur_pc = 32'h0000_4444; irq_code = 14'h2AB;
    irq_req = 1'b1; rte_strobe = 1'b1;
    @(negedge clk);
    rte_strobe = 1'b0;
    chk("R6 pc_load", {31'b0, pc_load}, 1);
    chk("R6 sr_load", {31'b0, sr_load}, 1);
    chk("R6 next_pc", next_pc, sv_pc);
    chk("R6 next_sr", next_sr, sv_sr);
    chk("R6 sgr kept", sgr, sv_gr);
    chk("R9 no accept", {31'b0, accept_pulse}, 0);
    @(negedge clk);
    irq_req = 1'b0;
    chk("R9 late accept", {31'b0, accept_pulse}, 1);
    chk("R9 spc", spc, 32'h0000_4444);
    chk("R9 sgr", sgr, 32'h1234_5678);
    sv_gr = sgr;
    // return alone, with r15 changed: saved register stays
    cur_r15 = 32'hDEAD_0001; rte_strobe = 1'b1;
    @(negedge clk);
    rte_strobe = 1'b0;
    chk("R6 next_pc", next_pc, 32'h0000_4444);
    chk("R6 sgr kept", sgr, sv_gr);
    @(negedge clk);
    chk("R6 sgr kept", sgr, sv_gr);
    chk("R10 loads drop", {30'b0, pc_load, sr_load}, 0);

    // R7: reset-type entry ignores block bit and mask, clears FD
    for (int u = 0; u < 2; u++) begin
      cur_sr = 32'h1000_80F0; irq_level = 4'd0; irq_reset_type = 1'b1;
      mask_upd_en = u[0]; vbr = 32'h0; irq_code = 14'h3FFF; irq_req = 1'b1;
      @(negedge clk);
      irq_req = 1'b0; irq_reset_type = 1'b0;
      chk("R7 accept", {31'b0, accept_pulse}, 1);
      chk("R7 next_sr", next_sr, exp_sr(32'h1000_80F0, 4'd0, u[0], 1'b1));
      chk("R4 next_pc", next_pc, 32'h600);
      chk("R3 intevt", intevt, 32'h0000_3FFF);
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule